// File: doc/BRIEF.md
# Split Direct-Mapped Address Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit virtual address space divided into 512-byte pages. It keeps two independent direct-mapped arrays of 64 entries each. The top address bit steers every access to one of them: the system array when it is set, the process array when it is clear. An entry holds a tag, a physical frame number, four per-mode read enables, four per-mode write enables and a modified flag.

A processor pipeline presents a virtual address, a mask of the access it wants and a write flag on the lookup port. The block answers in the same cycle with hit, the physical address and a tag-only presence flag. On a miss, an external fill engine walks the page tables and installs the converted entry through the fill port. Three invalidate commands let the operating system drop stale translations: all process entries, all entries, or the one entry a given address selects. When mapping is off, the arrays are skipped and the address passes straight through.

Top module: `xlat_buffer`

## Requirements
- R1: `lk_va[31]` = 1 selects the system array and 0 selects the process array. Both arrays use the same 6-bit index, the low 6 bits of the page number `va[14:9]`. Entries at the same index in the two arrays never disturb each other.
- R2: With mapping on, `lk_hit` is 1 only when two conditions hold. The stored tag must equal the full 23-bit page number `va[31:9]`. The entry's permission byte ANDed with `lk_acc` must also be nonzero. Bits [3:0] of the byte are read enables for modes kernel, executive, supervisor and user. Bits [7:4] are the write enables in the same mode order.
- R3: When `lk_write` = 1 and `lk_probe` = 0, a hit also requires the entry's modified flag. If that flag is clear, the lookup misses.
- R4: When `lk_probe` = 1, the modified flag plays no part in the hit decision.
- R5: On a mapped hit, `lk_pa` equals the entry's 21-bit frame number followed by `lk_va[8:0]`.
- R6: When `map_en` = 0, `lk_hit` = 1 and `lk_pa` = `lk_va[29:0]`, whatever the arrays hold.
- R7: `lk_tag_present` is 1 exactly when the indexed tag in the selected array equals the page number. It ignores permissions, the write flag and the modified flag.
- R8: A pulse on `inv_proc` invalidates every process entry and leaves the system entries intact.
- R9: A pulse on `inv_all` invalidates every entry in both arrays.
- R10: A pulse on `inv_one` invalidates only the entry indexed by `inv_va`, in the array chosen by `inv_va[31]`.
- R11: Reset invalidates every entry. An invalidated entry holds all ones in its tag and data fields, and it never hits or reports presence for any address, including page number all ones.
- R12: A `fill_en` pulse writes the entry in one clock, and the entry is visible to lookups in the next cycle. The write replaces the entry already at that index. An invalidation that hits the same entry in the same cycle takes precedence over the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_en | input | 1 | Translation enable |
| lk_va | input | 32 | Lookup virtual address |
| lk_acc | input | 8 | Requested access mask ([3:0] read per mode, [7:4] write per mode) |
| lk_write | input | 1 | Lookup is a write |
| lk_probe | input | 1 | Probe lookup, modified flag ignored |
| lk_hit | output | 1 | Translation usable |
| lk_pa | output | 30 | Physical address |
| lk_tag_present | output | 1 | Indexed tag matches the page number |
| fill_en | input | 1 | Install an entry |
| fill_va | input | 32 | Address whose page is installed |
| fill_pfn | input | 21 | Frame number to store |
| fill_perm | input | 8 | Permission byte to store |
| fill_mod | input | 1 | Modified flag to store |
| inv_proc | input | 1 | Invalidate the process array |
| inv_all | input | 1 | Invalidate both arrays |
| inv_one | input | 1 | Invalidate one entry |
| inv_va | input | 32 | Address selecting the entry for inv_one |

## Verification
The bench places a system entry and a process entry at the same index, then checks that every invalidate command removes only its own target. A shared array or an invalidate decoded on the wrong address bit would wipe out the neighbour entry. It writes through an entry whose modified flag is clear, once normally and once as a probe. A design that ignored the flag would hit on the normal write, and one that applied the flag to probes would miss on the probe. It also looks up page number all ones straight after reset, where an invalid tag of the same width as the page number would give a false hit. Finally, it pulses a fill together with a global invalidate, where a design that let the fill win would leave a live entry behind.

// File: rtl/xlat_pkg.sv
// Package: default geometry of the translation buffer and the layout of
// one entry's data word. Assumes byte-addressed pages and four modes.
package xlat_pkg;
    localparam int VA_W    = 32;  // virtual address width
    localparam int OFF_W   = 9;   // page offset width (512-byte pages)
    localparam int IDX_W   = 6;   // array index width
    localparam int PA_W    = 30;  // physical address width
    localparam int MODES   = 4;   // privilege modes

    // Array selected by the top address bit.
    typedef enum logic {ARR_PROC = 1'b0, ARR_SYS = 1'b1} arr_sel_e;
endpackage

// File: rtl/xlat_array.sv
// One direct-mapped array of tag/data pairs held in flip-flops.
// Assumes: clear requests beat a write to the same entry; cleared
// entries hold all ones in both tag and data.
module xlat_array #(
    parameter int IDX_W  = xlat_pkg::IDX_W,
    parameter int TAG_W  = 24,
    parameter int DATA_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_one,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_q  [ENTRIES];
    logic [DATA_W-1:0] data_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic kill;
        logic load;
        assign kill = clr_all || (clr_one && (clr_idx == IDX_W'(e)));
        assign load = wr_en && (wr_idx == IDX_W'(e));

        // Entry update: reset and clears invalidate, otherwise fill.
        always_ff @(posedge clk) begin
            if (!rst_n || kill) begin
                tag_q[e]  <= '1;
                data_q[e] <= '1;
            end else if (load) begin
                tag_q[e]  <= wr_tag;
                data_q[e] <= wr_data;
            end
        end
    end

    // Read port: combinational select of the indexed entry.
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    // R12
    fill_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all && !(clr_one && clr_idx == wr_idx))
        |=> (tag_q[$past(wr_idx)] == $past(wr_tag)
             && data_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/xlat_match.sv
// Hit decision for one selected entry: tag compare, permission check
// and modified-flag rule. Assumes data word = {mod, perm, pfn}.
module xlat_match #(
    parameter int VPN_W = 23,
    parameter int PFN_W = 21,
    parameter int MODES = xlat_pkg::MODES,
    localparam int TAG_W  = VPN_W + 1,
    localparam int PERM_W = 2 * MODES,
    localparam int DATA_W = PFN_W + PERM_W + 1
) (
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [DATA_W-1:0] ent_data,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [PERM_W-1:0] acc,
    input  logic              write,
    input  logic              probe,
    output logic              hit,
    output logic              present,
    output logic [PFN_W-1:0]  pfn
);
    logic [PERM_W-1:0] perm;
    logic              mod;

    // Field split of the stored data word.
    assign pfn  = ent_data[PFN_W-1:0];
    assign perm = ent_data[PFN_W +: PERM_W];
    assign mod  = ent_data[DATA_W-1];

    // Tag compare; the extra top tag bit is zero only for filled entries.
    assign present = (ent_tag == {1'b0, vpn});

    // Hit: tag, some granted access, and modified flag on plain writes.
    assign hit = present && (|(perm & acc)) && (!write || probe || mod);
endmodule

// File: rtl/xlat_buffer.sv
// Top of the split translation buffer: routes lookups, fills and
// invalidates to the process or system array by address bit VA_W-1,
// and bypasses both when mapping is disabled. Assumes PA_W > OFF_W.
module xlat_buffer #(
    parameter int VA_W  = xlat_pkg::VA_W,
    parameter int OFF_W = xlat_pkg::OFF_W,
    parameter int IDX_W = xlat_pkg::IDX_W,
    parameter int PA_W  = xlat_pkg::PA_W,
    parameter int MODES = xlat_pkg::MODES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 map_en,
    input  logic [VA_W-1:0]      lk_va,
    input  logic [2*MODES-1:0]   lk_acc,
    input  logic                 lk_write,
    input  logic                 lk_probe,
    output logic                 lk_hit,
    output logic [PA_W-1:0]      lk_pa,
    output logic                 lk_tag_present,
    input  logic                 fill_en,
    input  logic [VA_W-1:0]      fill_va,
    input  logic [PA_W-OFF_W-1:0] fill_pfn,
    input  logic [2*MODES-1:0]   fill_perm,
    input  logic                 fill_mod,
    input  logic                 inv_proc,
    input  logic                 inv_all,
    input  logic                 inv_one,
    input  logic [VA_W-1:0]      inv_va
);
    import xlat_pkg::*;

    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = PA_W - OFF_W;
    localparam int TAG_W  = VPN_W + 1;
    localparam int DATA_W = PFN_W + 2 * MODES + 1;

    logic [VPN_W-1:0]  lk_vpn;
    logic [IDX_W-1:0]  lk_idx;
    arr_sel_e          lk_sel;
    logic [TAG_W-1:0]  arr_tag  [2];
    logic [DATA_W-1:0] arr_data [2];
    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_data;
    logic              m_hit;
    logic [PFN_W-1:0]  m_pfn;

    // Lookup address split.
    assign lk_vpn = lk_va[VA_W-1:OFF_W];
    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_sel = arr_sel_e'(lk_va[VA_W-1]);

    for (genvar g = 0; g < 2; g++) begin : g_arr
        logic clr_all_g;
        logic clr_one_g;
        logic wr_en_g;
        // Process array also clears on inv_proc; system only on inv_all.
        assign clr_all_g = inv_all || ((g == 0) && inv_proc);
        assign clr_one_g = inv_one && (inv_va[VA_W-1] == 1'(g));
        assign wr_en_g   = fill_en && (fill_va[VA_W-1] == 1'(g));

        xlat_array #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) i_array (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_all(clr_all_g),
            .clr_one(clr_one_g),
            .clr_idx(inv_va[OFF_W +: IDX_W]),
            .wr_en  (wr_en_g),
            .wr_idx (fill_va[OFF_W +: IDX_W]),
            .wr_tag ({1'b0, fill_va[VA_W-1:OFF_W]}),
            .wr_data({fill_mod, fill_perm, fill_pfn}),
            .rd_idx (lk_idx),
            .rd_tag (arr_tag[g]),
            .rd_data(arr_data[g])
        );
    end

    // Select the entry of the array picked by the top address bit.
    assign sel_tag  = (lk_sel == ARR_SYS) ? arr_tag[1]  : arr_tag[0];
    assign sel_data = (lk_sel == ARR_SYS) ? arr_data[1] : arr_data[0];

    xlat_match #(
        .VPN_W(VPN_W),
        .PFN_W(PFN_W),
        .MODES(MODES)
    ) i_match (
        .ent_tag (sel_tag),
        .ent_data(sel_data),
        .vpn     (lk_vpn),
        .acc     (lk_acc),
        .write   (lk_write),
        .probe   (lk_probe),
        .hit     (m_hit),
        .present (lk_tag_present),
        .pfn     (m_pfn)
    );

    // Output select: translated result or pass-through when unmapped.
    always_comb begin
        if (map_en) begin
            lk_hit = m_hit;
            lk_pa  = {m_pfn, lk_va[OFF_W-1:0]};
        end else begin
            lk_hit = 1'b1;
            lk_pa  = lk_va[PA_W-1:0];
        end
    end

    // R7
    tag_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en && lk_hit) |-> lk_tag_present);

    // R3
    mod_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_en && lk_hit && lk_write && !lk_probe) |-> sel_data[DATA_W-1]);

    // R9
    inv_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !(map_en && lk_hit));

    // R8
    inv_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_proc |=> !(map_en && lk_hit && !lk_va[VA_W-1]));
endmodule

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  acc;
        logic        wr;
        logic        pr;
        logic        men;
        logic        ehit;
        logic [29:0] epa;
        logic        epres;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{32'h8000_0234, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 30'h0246_8A34, 1'b1}, // R5 R2
        '{32'h8000_0234, 8'h04, 1'b0, 1'b0, 1'b1, 1'b0, 30'h0,         1'b1}, // R2 no supv read
        '{32'h8000_0234, 8'h10, 1'b1, 1'b0, 1'b1, 1'b0, 30'h0,         1'b1}, // R3 mod clear
        '{32'h8000_0234, 8'h10, 1'b1, 1'b1, 1'b1, 1'b1, 30'h0246_8A34, 1'b1}, // R4 probe
        '{32'h0000_05FF, 8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 30'h0015_79FF, 1'b1}, // R5
        '{32'h0000_05FF, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 30'h0015_79FF, 1'b1}, // R3 mod set
        '{32'h0000_8210, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 30'h03E0_0010, 1'b1}, // R1 same idx
        '{32'h0000_0210, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 30'h0,         1'b0}, // R2 tag
        '{32'h8000_8200, 8'h01, 1'b0, 1'b0, 1'b1, 1'b0, 30'h0,         1'b0}, // R1 tag
        '{32'hC123_4567, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 30'h0123_4567, 1'b0}, // R6
        '{32'h8000_0200, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 30'h0,         1'b1}  // R7
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 4:    return "R5";
            1, 7:    return "R2";
            2, 5:    return "R3";
            3:       return "R4";
            6, 8:    return "R1";
            9:       return "R6";
            default: return "R7";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_en = 1'b1;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_acc = '0;
    logic        lk_write = 1'b0;
    logic        lk_probe = 1'b0;
    logic        lk_hit;
    logic [29:0] lk_pa;
    logic        lk_tag_present;
    logic        fill_en = 1'b0;
    logic [31:0] fill_va = '0;
    logic [20:0] fill_pfn = '0;
    logic [7:0]  fill_perm = '0;
    logic        fill_mod = 1'b0;
    logic        inv_proc = 1'b0;
    logic        inv_all = 1'b0;
    logic        inv_one = 1'b0;
    logic [31:0] inv_va = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    xlat_buffer i_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .map_en(map_en),
        .lk_va(lk_va), .lk_acc(lk_acc), .lk_write(lk_write), .lk_probe(lk_probe),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_tag_present(lk_tag_present),
        .fill_en(fill_en), .fill_va(fill_va), .fill_pfn(fill_pfn),
        .fill_perm(fill_perm), .fill_mod(fill_mod),
        .inv_proc(inv_proc), .inv_all(inv_all), .inv_one(inv_one), .inv_va(inv_va)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive a lookup at a falling edge and let the combinational path settle.
    task automatic look(input logic [31:0] va, input logic [7:0] acc,
                        input logic wr, input logic pr, input logic men);
        lk_va = va; lk_acc = acc; lk_write = wr; lk_probe = pr; map_en = men;
        #1;
    endtask

    task automatic do_fill(input logic [31:0] va, input logic [20:0] pfn,
                           input logic [7:0] perm, input logic md);
        @(negedge clk);
        fill_en = 1'b1; fill_va = va; fill_pfn = pfn; fill_perm = perm; fill_mod = md;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_inv(input logic p, input logic a, input logic o, input logic [31:0] va);
        @(negedge clk);
        inv_proc = p; inv_all = a; inv_one = o; inv_va = va;
        @(negedge clk);
        inv_proc = 1'b0; inv_all = 1'b0; inv_one = 1'b0;
    endtask

    task automatic fill_all3();
        do_fill(32'h8000_0200, 21'h12345, 8'h13, 1'b0); // system idx 1
        do_fill(32'h0000_0400, 21'h00ABC, 8'hFF, 1'b1); // process idx 2
        do_fill(32'h0000_8200, 21'h1F000, 8'h0F, 1'b0); // process idx 1
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset leaves every entry invalid, even for page number all ones
        look(32'h8000_0200, 8'hFF, 1'b0, 1'b0, 1'b1);
        check("R11 hit", 32'(lk_hit), 32'd0);
        check("R11 present", 32'(lk_tag_present), 32'd0);
        look(32'hFFFF_FE00, 8'hFF, 1'b0, 1'b1, 1'b1);
        check("R11 ones hit", 32'(lk_hit), 32'd0);
        check("R11 ones present", 32'(lk_tag_present), 32'd0);

        fill_all3();
        for (int i = 0; i < NVEC; i++) begin
            look(VECS[i].va, VECS[i].acc, VECS[i].wr, VECS[i].pr, VECS[i].men);
            check(vec_req(i), 32'(lk_hit), 32'(VECS[i].ehit));
            if (VECS[i].ehit) check(vec_req(i), 32'(lk_pa), 32'(VECS[i].epa));
            check("R7", 32'(lk_tag_present), 32'(VECS[i].epres));
        end

        // R10: single invalidate in system array spares process entry at idx 1
        do_inv(1'b0, 1'b0, 1'b1, 32'h8000_0300);
        look(32'h8000_0234, 8'h01, 1'b0, 1'b0, 1'b1);
        check("R10 sys gone", 32'(lk_hit), 32'd0);
        look(32'h0000_8210, 8'h01, 1'b0, 1'b0, 1'b1);
        check("R10 proc kept", 32'(lk_hit), 32'd1);

        // R10: single invalidate in process array spares system entry at idx 1
        do_fill(32'h8000_0200, 21'h12345, 8'h13, 1'b0);
        do_inv(1'b0, 1'b0, 1'b1, 32'h0000_0200);
        look(32'h8000_0234, 8'h01, 1'b0, 1'b0, 1'b1);
        check("R10 sys kept", 32'(lk_hit), 32'd1);
        look(32'h0000_8210, 8'h01, 1'b0, 1'b0, 1'b1);
        check("R10 proc gone", 32'(lk_hit), 32'd0);

        // R8: process clear keeps system entries
        fill_all3();
        do_inv(1'b1, 1'b0, 1'b0, 32'h0);
        look(32'h8000_0234, 8'h01, 1'b0, 1'b0, 1'b1);
        check("R8 sys kept", 32'(lk_hit), 32'd1);
        look(32'h0000_05FF, 8'h08, 1'b0, 1'b0, 1'b1);
        check("R8 proc gone", 32'(lk_hit), 32'd0);
        look(32'h0000_8210, 8'h01, 1'b0, 1'b0, 1'b1);
        check("R8 proc gone 2", 32'(lk_tag_present), 32'd0);

        // R9: global clear
        fill_all3();
        do_inv(1'b0, 1'b1, 1'b0, 32'h0);
        look(32'h8000_0234, 8'h01, 1'b0, 1'b0, 1'b1);
        check("R9 sys gone", 32'(lk_tag_present), 32'd0);
        look(32'h0000_05FF, 8'h08, 1'b0, 1'b0, 1'b1);
        check("R9 proc gone", 32'(lk_tag_present), 32'd0);

        // R12: invalidate in the same cycle as a fill wins
        @(negedge clk);
        fill_en = 1'b1; fill_va = 32'h0000_0400; fill_pfn = 21'h00ABC;
        fill_perm = 8'hFF; fill_mod = 1'b1; inv_all = 1'b1;
        @(negedge clk);
        fill_en = 1'b0; inv_all = 1'b0;
        look(32'h0000_05FF, 8'h08, 1'b0, 1'b0, 1'b1);
        check("R12 inv wins", 32'(lk_hit), 32'd0);

        // R12: fill to an occupied index replaces the old entry
        do_fill(32'h0000_0400, 21'h00ABC, 8'hFF, 1'b1);
        do_fill(32'h0000_8400, 21'h00777, 8'h01, 1'b0);
        look(32'h0000_05FF, 8'h08, 1'b0, 1'b0, 1'b1);
        check("R12 old gone", 32'(lk_tag_present), 32'd0);
        look(32'h0000_8400, 8'h01, 1'b0, 1'b0, 1'b1);
        check("R12 new hit", 32'(lk_hit), 32'd1);
        check("R12 new pa", 32'(lk_pa), 32'h000E_EE00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule